// File: doc/BRIEF.md
# Incremental Encoder Position Counter

This block turns the raw signals of an incremental shaft encoder into a position. Five inputs come in asynchronously: two count channels, an index pulse that marks one point per revolution, a home switch and a pause strobe. Each input is synchronized and then passed through a glitch filter. The count channels are decoded in one of three selectable ways: quadrature, pulse with a direction level, or separate up and down pulse lines. Each decoded count moves a phase counter. The phase counter wraps within a range that software sets as the number of counts per revolution minus one.

A second counter tracks whole revolutions. It follows one of two rules: it steps on every index pulse, or it steps whenever the phase counter wraps. The index pulse can also reload the phase counter with a programmed value. This lets the position be recalibrated once per turn. A rising home input clears whichever counters its mask selects. A pause level freezes the counters its own mask selects. A software clear holds both counters at zero while it is set. The block reports the phase count, the filtered levels of both count channels and the direction of the last count. It also gives one-cycle event pulses for the index and home inputs.

Top module: `qdec_counter`

## Requirements
- R1: After reset, `phase_cnt`, `rev_cnt` and `dir_down` are 0, and neither event pulse is active.
- R2: With `cfg_mode` = 0 (quadrature), the sequence {A,B} = 00, 10, 11, 01 counts up by one per transition, and the reverse sequence counts down by one. A transition in which A and B both change is ignored.
- R3: With `cfg_mode` = 1 (pulse and direction), each rising edge of A makes one count. The count is down when B is high and up when B is low. Edges of B and falling edges of A make no count.
- R4: With `cfg_mode` = 2 (up/down lines), a rising edge of A counts up and a rising edge of B counts down. With `cfg_mode` = 3 nothing is counted.
- R5: An up count from `cfg_phase_max` (or above it) gives 0. A down count from 0 gives `cfg_phase_max`.
- R6: With `cfg_rev_rule` = 0, a rising index input adds one to `rev_cnt` when `dir_down` is 0 and subtracts one when it is 1.
- R7: With `cfg_rev_rule` = 1, `rev_cnt` gains one on an up count that lands the phase count on `cfg_phase_max`. It loses one on a down count that lands the phase count on 0. The index input has no effect on it.
- R8: With `cfg_zcal_en` set, a rising index input loads `phase_cnt` with `cfg_index`.
- R9: A rising home input clears `rev_cnt` when `cfg_home_clr` bit 0 is set and `phase_cnt` when bit 1 is set. `home_event` and `z_event` each pulse for one cycle per rising edge of their input, in the cycle the counters react.
- R10: While the filtered pause input is high, `rev_cnt` holds if `cfg_pause_en` bit 0 is set and `phase_cnt` holds if bit 1 is set. `dir_down` still follows the counts.
- R11: While `sw_clear` is high, both counters read 0. This overrides every other source. Counting resumes from 0 after release.
- R12: A pulse on any input that lasts fewer than `FILT_CYCLES` clock cycles after synchronization is ignored. `a_level` and `b_level` show the filtered levels, and `dir_down` shows the direction of the most recent count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | 1 | Count channel A, asynchronous |
| in_b | input | 1 | Count channel B, asynchronous |
| in_z | input | 1 | Index pulse, asynchronous |
| in_home | input | 1 | Home switch, asynchronous |
| in_pause | input | 1 | Pause strobe, asynchronous |
| cfg_mode | input | 2 | 0 quadrature, 1 pulse/direction, 2 up/down, 3 off |
| cfg_phase_max | input | PW | Highest phase count (counts per turn minus one) |
| cfg_rev_rule | input | 1 | 0 step on index, 1 step on phase wrap |
| cfg_zcal_en | input | 1 | Index reloads phase counter |
| cfg_index | input | PW | Value loaded by the index |
| cfg_home_clr | input | 2 | Home clear mask: bit 0 revolutions, bit 1 phase |
| cfg_pause_en | input | 2 | Pause mask: bit 0 revolutions, bit 1 phase |
| sw_clear | input | 1 | Hold both counters at zero |
| phase_cnt | output | PW | Phase count |
| rev_cnt | output | RW | Revolution count |
| dir_down | output | 1 | 1 when the last count was downward |
| a_level | output | 1 | Filtered level of A |
| b_level | output | 1 | Filtered level of B |
| z_event | output | 1 | One-cycle pulse on a rising index input |
| home_event | output | 1 | One-cycle pulse on a rising home input |

## Verification
The assertions check four things on every cycle: the wrap at both ends of the phase range, the suppression of quadrature transitions where both channels change, the freeze under pause and the hold under software clear, and the clearing by home together with its one-cycle event pulses. The bench scenarios are needed for the rest. They show the decoded direction in each input mode, the revolution count under both update rules, the index reload, the home mask that leaves the phase alone, and the rejection of short glitches by the filter. These depend on sequences of input edges and on the bench's count of event pulses.

// File: rtl/qdec_pkg.sv
// Shared definitions for the encoder position counter.
// Assumes channel indices below are used consistently by all submodules.
package qdec_pkg;

    typedef enum logic [1:0] {
        MODE_QUAD     = 2'd0,
        MODE_PULSEDIR = 2'd1,
        MODE_UPDOWN   = 2'd2,
        MODE_OFF      = 2'd3
    } qdec_mode_e;

    localparam int CH_A     = 0;
    localparam int CH_B     = 1;
    localparam int CH_Z     = 2;
    localparam int CH_HOME  = 3;
    localparam int CH_PAUSE = 4;
    localparam int NUM_CH   = 5;

    // Bit positions inside the home-clear and pause masks.
    localparam int SEL_REV   = 0;
    localparam int SEL_PHASE = 1;

endpackage

// File: rtl/qdec_input_cond.sv
// Input conditioner: two-flop synchronizer then a persistence filter per channel.
// A filtered output only follows its synchronized input once the new level
// has been seen for FILT_CYCLES consecutive clocks. Assumes FILT_CYCLES >= 1.
module qdec_input_cond #(
    parameter int NCH         = 5,
    parameter int FILT_CYCLES = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] raw_in,
    output logic [NCH-1:0] filt_out
);
    localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic          meta_q;
        logic          sync_q;
        logic          out_q;
        logic [CW-1:0] run_q;

        // Two-stage synchronizer into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= raw_in[ch];
                sync_q <= meta_q;
            end
        end

        // Persistence filter: accept a new level after a full stable run.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_q <= 1'b0;
                run_q <= '0;
            end else if (sync_q != out_q) begin
                if (run_q == LAST) begin
                    out_q <= sync_q;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end

        assign filt_out[ch] = out_q;
    end

endmodule

// File: rtl/qdec_step_decoder.sv
// Step decoder: turns filtered channel levels into count steps and edge events.
// Holds last-cycle copies of each level; all outputs are valid in the cycle
// that follows a filtered level change. Assumes inputs are already filtered.
module qdec_step_decoder
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  qdec_mode_e mode,
    input  logic       lvl_a,
    input  logic       lvl_b,
    input  logic       lvl_z,
    input  logic       lvl_h,
    output logic       step,
    output logic       step_down,
    output logic       z_rise,
    output logic       h_rise
);
    logic a_prev, b_prev, z_prev, h_prev;

    // Remember last-cycle levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_prev <= 1'b0;
            b_prev <= 1'b0;
            z_prev <= 1'b0;
            h_prev <= 1'b0;
        end else begin
            a_prev <= lvl_a;
            b_prev <= lvl_b;
            z_prev <= lvl_z;
            h_prev <= lvl_h;
        end
    end

    logic a_chg, b_chg, a_up, b_up;
    assign a_chg = lvl_a ^ a_prev;
    assign b_chg = lvl_b ^ b_prev;
    assign a_up  = lvl_a & ~a_prev;
    assign b_up  = lvl_b & ~b_prev;

    // Per-mode step and direction selection.
    always_comb begin
        step      = 1'b0;
        step_down = 1'b0;
        unique case (mode)
            MODE_QUAD: begin
                step      = a_chg ^ b_chg;
                step_down = a_prev ^ lvl_b;
            end
            MODE_PULSEDIR: begin
                step      = a_up;
                step_down = lvl_b;
            end
            MODE_UPDOWN: begin
                step      = a_up ^ b_up;
                step_down = b_up;
            end
            default: begin
                step      = 1'b0;
                step_down = 1'b0;
            end
        endcase
    end

    assign z_rise = lvl_z & ~z_prev;
    assign h_rise = lvl_h & ~h_prev;

endmodule

// File: rtl/qdec_pos_core.sv
// Position core: phase counter with programmable wrap, revolution counter
// with two update rules, index reload, home clear, pause and software clear.
// Priority for the phase counter: clear, home, index reload, pause, count.
module qdec_pos_core
    import qdec_pkg::*;
#(
    parameter int PW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          step_down,
    input  logic          z_rise,
    input  logic          h_rise,
    input  logic          pause_lvl,
    input  logic [PW-1:0] phase_max,
    input  logic          rev_rule,
    input  logic          zcal_en,
    input  logic [PW-1:0] index_val,
    input  logic [1:0]    home_clr,
    input  logic [1:0]    pause_en,
    input  logic          sw_clear,
    output logic [PW-1:0] phase_q,
    output logic [RW-1:0] rev_q,
    output logic          dir_q,
    output logic          z_evt_q,
    output logic          h_evt_q
);
    logic          ph_paused, rv_paused, ph_home, rv_home, ph_load, ph_moves;
    logic [PW-1:0] ph_next_step, phase_d;
    logic [RW-1:0] rev_d;

    // Decode the control conditions that override counting.
    always_comb begin
        ph_paused = pause_lvl & pause_en[SEL_PHASE];
        rv_paused = pause_lvl & pause_en[SEL_REV];
        ph_home   = h_rise & home_clr[SEL_PHASE];
        rv_home   = h_rise & home_clr[SEL_REV];
        ph_load   = z_rise & zcal_en;
        ph_moves  = step & ~sw_clear & ~ph_home & ~ph_load & ~ph_paused;
    end

    // Compute the wrapped phase value one count away.
    always_comb begin
        if (!step_down)
            ph_next_step = (phase_q >= phase_max) ? '0 : phase_q + 1'b1;
        else
            ph_next_step = (phase_q == '0 || phase_q > phase_max) ? phase_max
                                                                   : phase_q - 1'b1;
    end

    // Select the next phase count by priority.
    always_comb begin
        if (sw_clear)       phase_d = '0;
        else if (ph_home)   phase_d = '0;
        else if (ph_load)   phase_d = index_val;
        else if (ph_paused) phase_d = phase_q;
        else if (step)      phase_d = ph_next_step;
        else                phase_d = phase_q;
    end

    // Select the next revolution count by priority and update rule.
    always_comb begin
        rev_d = rev_q;
        if (sw_clear) begin
            rev_d = '0;
        end else if (rv_home) begin
            rev_d = '0;
        end else if (!rv_paused) begin
            if (!rev_rule) begin
                if (z_rise) rev_d = dir_q ? rev_q - 1'b1 : rev_q + 1'b1;
            end else if (ph_moves) begin
                if (!step_down && ph_next_step == phase_max)
                    rev_d = rev_q + 1'b1;
                else if (step_down && ph_next_step == '0)
                    rev_d = rev_q - 1'b1;
            end
        end
    end

    // Register counters, direction and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            rev_q   <= '0;
            dir_q   <= 1'b0;
            z_evt_q <= 1'b0;
            h_evt_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            rev_q   <= rev_d;
            if (step) dir_q <= step_down;
            z_evt_q <= z_rise;
            h_evt_q <= h_rise;
        end
    end

endmodule

// File: rtl/qdec_counter.sv
// Top of the encoder position counter: conditions the five asynchronous
// inputs, decodes steps per the selected mode and updates the counters.
// Assumes configuration inputs are static or change only while idle.
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int PW          = 16,
    parameter int RW          = 16,
    parameter int FILT_CYCLES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_a,
    input  logic          in_b,
    input  logic          in_z,
    input  logic          in_home,
    input  logic          in_pause,
    input  logic [1:0]    cfg_mode,
    input  logic [PW-1:0] cfg_phase_max,
    input  logic          cfg_rev_rule,
    input  logic          cfg_zcal_en,
    input  logic [PW-1:0] cfg_index,
    input  logic [1:0]    cfg_home_clr,
    input  logic [1:0]    cfg_pause_en,
    input  logic          sw_clear,
    output logic [PW-1:0] phase_cnt,
    output logic [RW-1:0] rev_cnt,
    output logic          dir_down,
    output logic          a_level,
    output logic          b_level,
    output logic          z_event,
    output logic          home_event
);
    logic [NUM_CH-1:0] raw_vec, filt_vec;
    logic              dec_step, dec_down, evt_z, evt_h, lvl_pause;

    assign raw_vec[CH_A]     = in_a;
    assign raw_vec[CH_B]     = in_b;
    assign raw_vec[CH_Z]     = in_z;
    assign raw_vec[CH_HOME]  = in_home;
    assign raw_vec[CH_PAUSE] = in_pause;

    qdec_input_cond #(
        .NCH         (NUM_CH),
        .FILT_CYCLES (FILT_CYCLES)
    ) u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (raw_vec),
        .filt_out (filt_vec)
    );

    assign lvl_pause = filt_vec[CH_PAUSE];

    qdec_step_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (qdec_mode_e'(cfg_mode)),
        .lvl_a     (filt_vec[CH_A]),
        .lvl_b     (filt_vec[CH_B]),
        .lvl_z     (filt_vec[CH_Z]),
        .lvl_h     (filt_vec[CH_HOME]),
        .step      (dec_step),
        .step_down (dec_down),
        .z_rise    (evt_z),
        .h_rise    (evt_h)
    );

    qdec_pos_core #(
        .PW (PW),
        .RW (RW)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (dec_step),
        .step_down (dec_down),
        .z_rise    (evt_z),
        .h_rise    (evt_h),
        .pause_lvl (lvl_pause),
        .phase_max (cfg_phase_max),
        .rev_rule  (cfg_rev_rule),
        .zcal_en   (cfg_zcal_en),
        .index_val (cfg_index),
        .home_clr  (cfg_home_clr),
        .pause_en  (cfg_pause_en),
        .sw_clear  (sw_clear),
        .phase_q   (phase_cnt),
        .rev_q     (rev_cnt),
        .dir_q     (dir_down),
        .z_evt_q   (z_event),
        .h_evt_q   (home_event)
    );

    assign a_level = filt_vec[CH_A];
    assign b_level = filt_vec[CH_B];

endmodule

// File: rtl/qdec_counter_checker.sv
// Property checker for qdec_counter, attached through bind below.
// Observes top ports plus the decoder outputs that feed the counter core.
module qdec_counter_checker #(
    parameter int PW = 16,
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_mode,
    input logic [PW-1:0] cfg_phase_max,
    input logic          cfg_zcal_en,
    input logic [1:0]    cfg_home_clr,
    input logic [1:0]    cfg_pause_en,
    input logic          sw_clear,
    input logic [PW-1:0] phase_cnt,
    input logic [RW-1:0] rev_cnt,
    input logic          a_level,
    input logic          b_level,
    input logic          z_event,
    input logic          home_event,
    input logic          dec_step,
    input logic          dec_down,
    input logic          evt_z,
    input logic          evt_h,
    input logic          lvl_pause
);
    logic ph_quiet;
    assign ph_quiet = !sw_clear && !(evt_h && cfg_home_clr[1])
                   && !(evt_z && cfg_zcal_en) && !(lvl_pause && cfg_pause_en[1]);

    assert_clear_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clear |=> (phase_cnt == '0 && rev_cnt == '0));

    assert_up_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_step && !dec_down && phase_cnt >= cfg_phase_max && ph_quiet)
        |=> phase_cnt == '0);

    assert_down_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_step && dec_down && phase_cnt == '0 && ph_quiet)
        |=> phase_cnt == $past(cfg_phase_max));

    assert_both_change_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd0 && a_level != $past(a_level) && b_level != $past(b_level)
         && ph_quiet) |=> $stable(phase_cnt));

    assert_home_clears_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (home_event && $past(cfg_home_clr[1]) && !$past(sw_clear)) |-> phase_cnt == '0);

    assert_event_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (z_event || home_event) |=> !(z_event && home_event && $past(z_event && home_event)));

    assert_z_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        z_event |=> !z_event);

    assert_phase_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_pause && cfg_pause_en[1] && !sw_clear && !(evt_h && cfg_home_clr[1])
         && !(evt_z && cfg_zcal_en)) |=> $stable(phase_cnt));

    assert_rev_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_pause && cfg_pause_en[0] && !sw_clear && !(evt_h && cfg_home_clr[0]))
        |=> $stable(rev_cnt));

endmodule

bind qdec_counter qdec_counter_checker #(.PW(PW), .RW(RW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_phase_max (cfg_phase_max),
    .cfg_zcal_en   (cfg_zcal_en),
    .cfg_home_clr  (cfg_home_clr),
    .cfg_pause_en  (cfg_pause_en),
    .sw_clear      (sw_clear),
    .phase_cnt     (phase_cnt),
    .rev_cnt       (rev_cnt),
    .a_level       (a_level),
    .b_level       (b_level),
    .z_event       (z_event),
    .home_event    (home_event),
    .dec_step      (dec_step),
    .dec_down      (dec_down),
    .evt_z         (evt_z),
    .evt_h         (evt_h),
    .lvl_pause     (lvl_pause)
);

// File: tb/qdec_counter_test.sv
module qdec_counter_test;
    localparam int PW = 16;
    localparam int RW = 16;
    localparam int SETTLE = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_a = 0, in_b = 0, in_z = 0, in_home = 0, in_pause = 0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [PW-1:0] cfg_phase_max = 16'd7;
    logic          cfg_rev_rule = 1'b1;
    logic          cfg_zcal_en = 1'b0;
    logic [PW-1:0] cfg_index = 16'd5;
    logic [1:0]    cfg_home_clr = 2'b00;
    logic [1:0]    cfg_pause_en = 2'b00;
    logic          sw_clear = 1'b0;
    logic [PW-1:0] phase_cnt;
    logic [RW-1:0] rev_cnt;
    logic dir_down, a_level, b_level, z_event, home_event;

    always #10 clk = ~clk;

    qdec_counter #(.PW(PW), .RW(RW), .FILT_CYCLES(3)) uut (
        .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_z(in_z),
        .in_home(in_home), .in_pause(in_pause), .cfg_mode(cfg_mode),
        .cfg_phase_max(cfg_phase_max), .cfg_rev_rule(cfg_rev_rule),
        .cfg_zcal_en(cfg_zcal_en), .cfg_index(cfg_index),
        .cfg_home_clr(cfg_home_clr), .cfg_pause_en(cfg_pause_en),
        .sw_clear(sw_clear), .phase_cnt(phase_cnt), .rev_cnt(rev_cnt),
        .dir_down(dir_down), .a_level(a_level), .b_level(b_level),
        .z_event(z_event), .home_event(home_event)
    );

    typedef struct {
        string         tag;
        logic [PW-1:0] ph;
        logic [RW-1:0] rv;
        logic          dr;
        int            zc;
        int            hc;
    } exp_t;

    exp_t q[$];
    int checks = 0, fails = 0;
    int zc_seen = 0, hc_seen = 0;
    bit done = 0;

    // Bench model of the expected state.
    logic [PW-1:0] m_ph = '0;
    logic [RW-1:0] m_rv = '0;
    logic          m_dr = 1'b0;
    int            m_zc = 0, m_hc = 0;
    logic [1:0]    qidx = 2'd0;

    // Monitor: count event pulses and compare queued expectations.
    always @(negedge clk) begin
        if (rst_n) begin
            if (z_event) zc_seen++;
            if (home_event) hc_seen++;
        end
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (phase_cnt !== e.ph || rev_cnt !== e.rv || dir_down !== e.dr ||
                zc_seen != e.zc || hc_seen != e.hc) begin
                fails++;
                $display("FAIL %s: got ph=%0d rv=%0h dir=%0b z=%0d h=%0d, exp ph=%0d rv=%0h dir=%0b z=%0d h=%0d",
                         e.tag, phase_cnt, rev_cnt, dir_down, zc_seen, hc_seen,
                         e.ph, e.rv, e.dr, e.zc, e.hc);
            end
        end
    end

    task automatic expect_now(input string tag);
        exp_t e;
        e.tag = tag; e.ph = m_ph; e.rv = m_rv; e.dr = m_dr; e.zc = m_zc; e.hc = m_hc;
        q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp_v);
        checks++;
        if (got !== exp_v) begin
            fails++;
            $display("FAIL %s: got %0b exp %0b", tag, got, exp_v);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic drive_ab(input logic na, input logic nb);
        @(negedge clk);
        in_a = na; in_b = nb;
        settle();
    endtask

    // Model one count under R5 and R7 (no overrides active).
    task automatic model_count(input logic down);
        logic [PW-1:0] nxt;
        m_dr = down;
        if (!down) nxt = (m_ph >= cfg_phase_max) ? '0 : m_ph + 1'b1;
        else       nxt = (m_ph == '0) ? cfg_phase_max : m_ph - 1'b1;
        if (cfg_rev_rule) begin
            if (!down && nxt == cfg_phase_max) m_rv = m_rv + 1'b1;
            if (down && nxt == '0)             m_rv = m_rv - 1'b1;
        end
        m_ph = nxt;
    endtask

    task automatic quad_move(input logic down);
        qidx = down ? qidx - 2'd1 : qidx + 2'd1;
        drive_ab(qidx[0] ^ qidx[1], qidx[1]);
        model_count(down);
    endtask

    task automatic pulse_a();
        drive_ab(1'b1, in_b);
        drive_ab(1'b0, in_b);
    endtask

    task automatic pulse_b();
        drive_ab(in_a, 1'b1);
        drive_ab(in_a, 1'b0);
    endtask

    task automatic pulse_z();
        @(negedge clk); in_z = 1'b1; settle();
        @(negedge clk); in_z = 1'b0; settle();
        m_zc++;
    endtask

    task automatic pulse_home();
        @(negedge clk); in_home = 1'b1; settle();
        @(negedge clk); in_home = 1'b0; settle();
        m_hc++;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();
        expect_now("R1 reset state");
        check_bit("R1 z_event idle", z_event, 1'b0);
        check_bit("R1 home_event idle", home_event, 1'b0);

        // R2/R7: seven quadrature up counts, landing on max bumps revolutions.
        for (int i = 0; i < 7; i++) quad_move(1'b0);
        expect_now("R2 R7 up to max");
        quad_move(1'b0);
        expect_now("R5 up wrap to 0");
        for (int i = 0; i < 2; i++) quad_move(1'b0);
        for (int i = 0; i < 3; i++) quad_move(1'b1);
        expect_now("R2 R5 R7 down through 0");

        // R2: both channels toggling together is ignored.
        drive_ab(~in_a, ~in_b);
        qidx = {in_b, in_a ^ in_b};
        expect_now("R2 illegal transition ignored");

        // R12: short glitch on B is filtered out.
        @(negedge clk); in_b = ~in_b;
        repeat (2) @(negedge clk); in_b = ~in_b;
        settle();
        expect_now("R12 glitch ignored");
        check_bit("R12 a_level", a_level, in_a);
        check_bit("R12 b_level", b_level, in_b);

        // R3: pulse and direction.
        cfg_mode = 2'd1;
        drive_ab(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin pulse_a(); model_count(1'b0); end
        drive_ab(1'b0, 1'b1);
        for (int i = 0; i < 2; i++) begin pulse_a(); model_count(1'b1); end
        expect_now("R3 pulse/direction");

        // R4: up/down lines.
        cfg_mode = 2'd2;
        drive_ab(1'b0, 1'b0);
        for (int i = 0; i < 2; i++) begin pulse_a(); model_count(1'b0); end
        pulse_b(); model_count(1'b1);
        expect_now("R4 up/down lines");

        // R4: mode 3 counts nothing.
        cfg_mode = 2'd3;
        pulse_a(); pulse_b();
        expect_now("R4 mode off");

        // R6: index steps revolutions by direction.
        cfg_mode = 2'd2;
        cfg_rev_rule = 1'b0;
        pulse_z(); m_rv = m_dr ? m_rv - 1'b1 : m_rv + 1'b1;
        pulse_a(); model_count(1'b0);
        pulse_z(); m_rv = m_dr ? m_rv - 1'b1 : m_rv + 1'b1;
        expect_now("R6 R9 index revolution count");

        // R8: index reload of phase.
        cfg_zcal_en = 1'b1;
        pulse_z(); m_ph = cfg_index; m_rv = m_rv + 1'b1;
        expect_now("R8 index reload");
        pulse_z(); m_ph = cfg_index; m_rv = m_rv + 1'b1;

        // R9: home masks.
        cfg_home_clr = 2'b01;
        pulse_home(); m_rv = '0;
        expect_now("R9 home clears revolutions only");
        cfg_home_clr = 2'b10;
        pulse_home(); m_ph = '0;
        expect_now("R9 home clears phase only");
        cfg_home_clr = 2'b00;

        // R10: pause masks.
        cfg_zcal_en = 1'b0;
        cfg_pause_en = 2'b10;
        @(negedge clk); in_pause = 1'b1; settle();
        pulse_a(); m_dr = 1'b0;
        pulse_z(); m_rv = m_rv + 1'b1;
        expect_now("R10 phase paused");
        cfg_pause_en = 2'b01;
        pulse_z();
        pulse_a(); model_count(1'b0);
        expect_now("R10 revolutions paused");
        @(negedge clk); in_pause = 1'b0; settle();

        // R11: software clear.
        @(negedge clk); sw_clear = 1'b1; settle();
        m_ph = '0; m_rv = '0;
        pulse_a(); pulse_a(); m_dr = 1'b0;
        expect_now("R11 held at zero");
        @(negedge clk); sw_clear = 1'b0; settle();
        pulse_a(); model_count(1'b0);
        expect_now("R11 resumes after release");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule